// File: doc/BRIEF.md
# Memory Low-Power State Controller

This controller keeps track of the power state of a single memory device. The device can be active, standby, nap or power-down. Decoded row-packet commands arrive on separate strobes: attention, relax, nap entry and power-down entry. The controller moves between states on these commands. Leaving nap or power-down is requested by an external wake-up decoder through a single exit strobe.

On entry, the controller stores the state to return to on exit. A relax command carried in the same packet as the entry command changes that stored state to standby. The controller checks that the entry preconditions are met. It also watches for packets during a quiet window that follows the entry command. Three programmable lockouts are applied: an entry latency, a block on re-entry after an exit, and a block on exit after a nap entry. Any rule that is broken sets a sticky violation flag. A one-cycle pulse asks the output-drive current and slew logic to restore their settings after a power-down exit.

Top module: `lp_state_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the controller resets. It goes to standby (`state` = 2'd1), all lockout counters clear, and `violation`, `entering` and `drive_restore` go low. The state encoding is active = 0, standby = 1, nap = 2, power-down = 3.
- R2: With no entry command present, `cmd_attn` moves standby to active and `cmd_relax` moves active to standby.
- R3: An entry command is honoured only in active or standby with the re-entry counter at zero. When both entry strobes are high, power-down wins. In nap or power-down, an entry command leaves the state unchanged.
- R4: On an accepted exit, the state becomes the resume state. The resume state was recorded at entry as the state held then. If the state was active and `cmd_relax` arrived with the entry command, standby is recorded instead.
- R5: An accepted entry while `wbuf_retired` is low, or while `banks_precharged` is low, sets `violation`. The precharge condition is waived for nap entry when `selfref_nap_en` is low.
- R6: `pkt_seen` sets `violation` in any of the `quiet_len` cycles that follow an accepted entry command, and only in those cycles.
- R7: An entry command is ignored in each of the `reentry_len` cycles that follow an accepted exit.
- R8: After a nap entry, `exit_strobe` is ignored in each of the `reexit_len` cycles that follow it. Power-down entry sets no exit lockout.
- R9: `entering` is high for `nap_lat` cycles after a nap entry and for `pdn_lat` cycles after a power-down entry. It is counted from the first cycle after the entry edge. An exit clears it.
- R10: `drive_restore` is high for exactly the one cycle after an exit from power-down. It stays low after an exit from nap.
- R11: `violation` stays high until `viol_clr` is asserted. If a new violation occurs in the same cycle as `viol_clr`, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_attn | input | 1 | Attention command decoded from a row packet |
| cmd_relax | input | 1 | Relax command decoded from a row packet |
| cmd_nap | input | 1 | Nap-entry command |
| cmd_pdn | input | 1 | Power-down-entry command |
| wbuf_retired | input | 1 | Write buffer has been retired |
| banks_precharged | input | 1 | All banks are precharged |
| selfref_nap_en | input | 1 | Self-refresh in nap is enabled |
| pkt_seen | input | 1 | A broadcast packet, or a packet for this device, is present |
| exit_strobe | input | 1 | Exit request from the wake-up decoder |
| viol_clr | input | 1 | Clears the violation flag |
| quiet_len | input | CW | Length of the quiet window, in cycles |
| reentry_len | input | CW | Length of the re-entry lockout, in cycles |
| reexit_len | input | CW | Length of the exit lockout after nap entry, in cycles |
| nap_lat | input | CW | Nap entry latency, in cycles |
| pdn_lat | input | CW | Power-down entry latency, in cycles |
| state | output | 2 | Current power state |
| violation | output | 1 | Sticky violation flag |
| entering | output | 1 | Entry latency is still running |
| drive_restore | output | 1 | Pulse that asks drive and slew control to restore their settings |

## Verification
Every output is a register, or decodes a register, that is updated at the clock edge which samples the stimulus. Each result is therefore due one edge after the cycle in which its command is driven. The driver applies inputs on the falling edge and queues the outputs it expects after the next rising edge. The monitor pops each item 2 ns after that rising edge. The lockout and window boundaries are placed in exact cycles: the last blocked cycle and the first free cycle. This way an off-by-one in any counter moves a state or flag change by one queued item.

// File: rtl/lp_state_ctrl.sv
module lp_state_ctrl #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_attn,
  input  logic          cmd_relax,
  input  logic          cmd_nap,
  input  logic          cmd_pdn,
  input  logic          wbuf_retired,
  input  logic          banks_precharged,
  input  logic          selfref_nap_en,
  input  logic          pkt_seen,
  input  logic          exit_strobe,
  input  logic          viol_clr,
  input  logic [CW-1:0] quiet_len,
  input  logic [CW-1:0] reentry_len,
  input  logic [CW-1:0] reexit_len,
  input  logic [CW-1:0] nap_lat,
  input  logic [CW-1:0] pdn_lat,
  output logic [1:0]    state,
  output logic          violation,
  output logic          entering,
  output logic          drive_restore
);
  localparam logic [1:0] S_ACT = 2'd0, S_STBY = 2'd1, S_NAP = 2'd2, S_PDN = 2'd3;
  localparam logic [CW-1:0] ZERO = '0;

  logic [1:0]    resume_q;
  logic [CW-1:0] quiet_cnt, reentry_cnt, reexit_cnt, ent_cnt;

  wire low_pwr   = state[1];
  wire want_in   = cmd_nap | cmd_pdn;
  wire go_entry  = !low_pwr && want_in && (reentry_cnt == ZERO);
  wire go_exit   = low_pwr && exit_strobe && (reexit_cnt == ZERO);
  wire pre_ok    = wbuf_retired && (banks_precharged || (!cmd_pdn && !selfref_nap_en));
  wire viol_set  = (pkt_seen && quiet_cnt != ZERO) || (go_entry && !pre_ok);

  assign entering = (ent_cnt != ZERO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= S_STBY;
      resume_q      <= S_STBY;
      quiet_cnt     <= '0;
      reentry_cnt   <= '0;
      reexit_cnt    <= '0;
      ent_cnt       <= '0;
      violation     <= 1'b0;
      drive_restore <= 1'b0;
    end else begin
      if (quiet_cnt   != ZERO) quiet_cnt   <= quiet_cnt - 1'b1;
      if (reentry_cnt != ZERO) reentry_cnt <= reentry_cnt - 1'b1;
      if (reexit_cnt  != ZERO) reexit_cnt  <= reexit_cnt - 1'b1;
      if (ent_cnt     != ZERO) ent_cnt     <= ent_cnt - 1'b1;
      drive_restore <= 1'b0;

      if (viol_set)      violation <= 1'b1;
      else if (viol_clr) violation <= 1'b0;

      if (go_exit) begin
        state         <= resume_q;
        reentry_cnt   <= reentry_len;
        ent_cnt       <= '0;
        drive_restore <= (state == S_PDN);
      end else if (go_entry) begin
        state      <= cmd_pdn ? S_PDN : S_NAP;
        resume_q   <= (state == S_ACT && !cmd_relax) ? S_ACT : S_STBY;
        quiet_cnt  <= quiet_len;
        ent_cnt    <= cmd_pdn ? pdn_lat : nap_lat;
        reexit_cnt <= cmd_pdn ? ZERO : reexit_len;
      end else if (!low_pwr && !want_in) begin
        if (cmd_attn && state == S_STBY)       state <= S_ACT;
        else if (cmd_relax && state == S_ACT)  state <= S_STBY;
      end
    end
  end

  // R3
  nap_no_pdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_NAP) |=> (state != S_PDN));
  // R3
  pdn_no_nap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PDN) |=> (state != S_NAP));
  // R7
  reentry_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!low_pwr && reentry_cnt != ZERO) |=> !low_pwr);
  // R8
  reexit_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_NAP && reexit_cnt != ZERO) |=> (state == S_NAP));
  // R9
  entering_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entering |-> low_pwr);
  // R10
  restore_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_restore |-> ($past(state) == S_PDN && !low_pwr));
  // R11
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (violation && !viol_clr) |=> violation);
endmodule

// File: tb/test_lp_state_ctrl.sv
module test_lp_state_ctrl;
  localparam int CW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_attn = 0, cmd_relax = 0, cmd_nap = 0, cmd_pdn = 0;
  logic wbuf_retired = 1, banks_precharged = 1, selfref_nap_en = 1;
  logic pkt_seen = 0, exit_strobe = 0, viol_clr = 0;
  logic [CW-1:0] quiet_len = 8'd3, reentry_len = 8'd4, reexit_len = 8'd3;
  logic [CW-1:0] nap_lat = 8'd2, pdn_lat = 8'd3;
  logic [1:0] state;
  logic violation, entering, drive_restore;

  lp_state_ctrl #(.CW(CW)) i_lp_state_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_attn(cmd_attn), .cmd_relax(cmd_relax),
    .cmd_nap(cmd_nap), .cmd_pdn(cmd_pdn), .wbuf_retired(wbuf_retired),
    .banks_precharged(banks_precharged), .selfref_nap_en(selfref_nap_en),
    .pkt_seen(pkt_seen), .exit_strobe(exit_strobe), .viol_clr(viol_clr),
    .quiet_len(quiet_len), .reentry_len(reentry_len), .reexit_len(reexit_len),
    .nap_lat(nap_lat), .pdn_lat(pdn_lat), .state(state), .violation(violation),
    .entering(entering), .drive_restore(drive_restore));

  always #4 clk = ~clk;

  typedef struct { string req; logic [1:0] st; logic v, en, dr; } exp_t;
  exp_t q[$];
  int vectors = 0, errors = 0;
  bit done = 0;

  task automatic step(input logic a, n, p, rl, pk, ex, cl,
                      input string r, input logic [1:0] st, input logic v, en, dr);
    exp_t e;
    @(negedge clk);
    cmd_attn = a; cmd_nap = n; cmd_pdn = p; cmd_relax = rl;
    pkt_seen = pk; exit_strobe = ex; viol_clr = cl;
    e.req = r; e.st = st; e.v = v; e.en = en; e.dr = dr;
    q.push_back(e);
  endtask

  task automatic idle(input string r, input logic [1:0] st, input logic v, en, dr);
    step(0, 0, 0, 0, 0, 0, 0, r, st, v, en, dr);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      vectors++;
      if (state !== e.st || violation !== e.v || entering !== e.en || drive_restore !== e.dr) begin
        errors++;
        $display("FAIL %s: got st=%0d v=%b en=%b dr=%b, expected st=%0d v=%b en=%b dr=%b",
                 e.req, state, violation, entering, drive_restore, e.st, e.v, e.en, e.dr);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (state !== 2'd1 || violation !== 1'b0 || entering !== 1'b0 || drive_restore !== 1'b0) begin
      errors++;
      $display("FAIL R1: got st=%0d v=%b en=%b dr=%b, expected st=1 v=0 en=0 dr=0",
               state, violation, entering, drive_restore);
    end
    rst_n = 1'b1;
    idle("R1", 1, 0, 0, 0);
    step(1,0,0,0,0,0,0, "R2 attn", 0, 0, 0, 0);
    step(0,1,0,0,0,0,0, "R9 nap entry", 2, 0, 1, 0);
    step(0,0,1,0,0,0,0, "R3 pdn in nap", 2, 0, 1, 0);
    step(0,0,0,0,0,1,0, "R8 exit locked", 2, 0, 0, 0);
    idle("R8", 2, 0, 0, 0);
    step(0,0,0,0,0,1,0, "R4 resume active", 0, 0, 0, 0);
    step(0,1,0,0,0,0,0, "R7 reentry locked", 0, 0, 0, 0);
    idle("R7", 0, 0, 0, 0);
    idle("R7", 0, 0, 0, 0);
    idle("R7", 0, 0, 0, 0);
    step(0,0,1,1,0,0,0, "R4 pdn with relax", 3, 0, 1, 0);
    step(0,0,0,0,1,0,0, "R6 quiet packet", 3, 1, 1, 0);
    step(0,0,0,0,0,0,1, "R11 clear", 3, 0, 1, 0);
    idle("R9 pdn latency end", 3, 0, 0, 0);
    step(0,0,0,0,1,0,0, "R6 window over", 3, 0, 0, 0);
    step(0,0,0,0,0,1,0, "R10 pdn exit restore", 1, 0, 0, 1);
    idle("R10 pulse one cycle", 1, 0, 0, 0);
    idle("R7", 1, 0, 0, 0);
    idle("R7", 1, 0, 0, 0);
    idle("R7", 1, 0, 0, 0);
    @(negedge clk); banks_precharged = 0; selfref_nap_en = 0;
    step(0,1,0,0,0,0,0, "R5 waiver", 2, 0, 1, 0);
    idle("R9", 2, 0, 1, 0);
    idle("R9", 2, 0, 0, 0);
    idle("R8", 2, 0, 0, 0);
    step(0,0,0,0,0,1,0, "R4 R10 nap exit to standby", 1, 0, 0, 0);
    idle("R7", 1, 0, 0, 0);
    idle("R7", 1, 0, 0, 0);
    idle("R7", 1, 0, 0, 0);
    idle("R7", 1, 0, 0, 0);
    @(negedge clk); selfref_nap_en = 1;
    step(0,0,1,0,0,0,0, "R5 pdn not precharged", 3, 1, 1, 0);
    step(0,0,0,0,1,0,1, "R11 set beats clear", 3, 1, 1, 0);
    step(0,0,0,0,0,0,1, "R11 clear", 3, 0, 1, 0);
    @(negedge clk); banks_precharged = 1;
    step(0,0,0,0,0,1,0, "R10 pdn exit", 1, 0, 0, 1);
    step(1,0,0,0,0,0,0, "R2 attn", 0, 0, 0, 0);
    step(0,0,0,1,0,0,0, "R2 relax", 1, 0, 0, 0);
    idle("R2", 1, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule